// File: doc/BRIEF.md
# Event-Driven Atomic Component Sequencer

This block is the hardware form of one atomic component in a discrete-event model. It keeps a one-hot current state and a countdown armed from that state's lifespan. It also keeps one pending flag for each input port. A coordinator drives it through two phases. In the speak phase the component reports whether it is due and, if so, presents that state's output value. In the move phase it takes at most one transition. A due component moves along its scheduled next state. A component that is not due but holds a pending input follows the edge that the input selects. The whole state graph comes from parameters: lifespans, scheduled successors, output values, which ports each state listens to, and where each port leads.

A lifespan of all ones stands for "never", so no countdown runs and only an input can leave the state. A lifespan of zero makes the component due on entry. If the countdown runs out while an input is waiting, the component does not become due and the input is served at the next move. A strobe on a port that the current state does not listen to is thrown away. A strobe that lands in the same cycle as a move that changes state is also thrown away, together with the flags that the move clears. When the component is due and also holds an input, the scheduled transition wins.

Top module: `evseq_atomic`

## Requirements
- R1: A state whose lifespan is all ones never raises `imminent`; a move request there changes state only when an input flag is pending.
- R2: Entering a state with lifespan 0 raises `imminent` right after the entering clock edge; with lifespan k>0, `imminent` goes high exactly k rising edges after the entering edge (the last reset edge counts as entering state 0).
- R3: If the countdown reaches its end while a listened input flag is pending, `imminent` stays low.
- R4: `speak_ack` pulses one cycle after `speak_req`; in that cycle `out_valid` is 1 and `out_data` holds the current state's output value when the component is imminent, otherwise `out_valid` and `out_data` are 0.
- R5: A move request while imminent goes to the state's scheduled successor, clears `imminent` (unless the new lifespan is 0) and rearms the countdown from the new state; `move_ack` pulses one cycle after every `move_req`.
- R6: A move request while not imminent with pending flags goes to the state selected by the lowest-numbered pending port (port 0 has top priority), clears every flag and restarts the countdown from the new state's lifespan.
- R7: A strobe on a port the current state does not listen to leaves no flag, so it neither blocks imminence nor causes a transition.
- R8: When imminent and holding a pending flag, a move takes the scheduled transition and the pending flag is discarded.
- R9: A move request with neither imminence nor a pending flag leaves the state unchanged.
- R10: After reset, `cur_state` is one-hot bit 0, `imminent`, `speak_ack`, `move_ack` and `out_valid` are 0.
- R11: `cur_state` is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speak_req | input | 1 | Coordinator asks for the output phase |
| speak_ack | output | 1 | Output phase done, one cycle after request |
| out_valid | output | 1 | Output event present in the acknowledged phase |
| out_data | output | OUT_W | Output value of the state that spoke |
| move_req | input | 1 | Coordinator asks for the transition phase |
| move_ack | output | 1 | Transition phase done, one cycle after request |
| in_strobe | input | N_PORTS | One pulse per arriving input event, per port |
| cur_state | output | N_STATES | One-hot current state |
| imminent | output | 1 | Component is due for its scheduled transition |

## Verification
The bench builds the block with its default parameters: four states, two input ports and 4-bit lifespans. In that table state 0 lasts 3 cycles, state 1 lasts 0, state 2 lasts forever and state 3 lasts 5. State 2 listens to both ports, state 3 to neither, and states 0 and 1 each listen to one. This single small table puts every case in reach: an immediate due state, a state that never times out, a deaf state, a timeout masked by a pending input, two ports striking together and the due-plus-input conflict. Every lifespan is a handful of cycles, so each timing edge is checked at its exact cycle.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    localparam int IDX_MAX_W = 8;

    typedef enum logic [1:0] {
        MV_NONE     = 2'd0,
        MV_INTERNAL = 2'd1,
        MV_EXTERNAL = 2'd2
    } move_kind_e;

    typedef struct packed {
        move_kind_e             kind;
        logic [IDX_MAX_W-1:0]   next_idx;
    } move_dec_t;

    function automatic logic ta_never(input logic [31:0] ta, input int w);
        logic [31:0] mask;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (ta & mask) == mask;
    endfunction

endpackage

// File: rtl/evseq_timer.sv
module evseq_timer
    import evseq_pkg::*;
#(
    parameter int TA_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enter_i,
    input  logic [TA_W-1:0] enter_ta_i,
    input  logic [TA_W-1:0] reset_ta_i,
    input  logic            pending_i,
    output logic            imminent_o
);

    logic [TA_W-1:0] cnt_q;
    logic            armed_q;
    logic            imm_q;
    logic [TA_W-1:0] load_ta;
    logic            load_never;
    logic            load_zero;

    always_comb begin
        load_ta    = rst ? reset_ta_i : enter_ta_i;
        load_never = ta_never(32'(load_ta), TA_W);
        load_zero  = (load_ta == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || enter_i) begin
            cnt_q   <= load_ta;
            armed_q <= !load_never && !load_zero;
            imm_q   <= load_zero;
        end else if (armed_q) begin
            if (cnt_q == TA_W'(1)) begin
                armed_q <= 1'b0;
                imm_q   <= !pending_i;
            end else begin
                cnt_q <= cnt_q - TA_W'(1);
            end
        end
    end

    assign imminent_o = imm_q;

    assert_zero_ta_due_R2: assert property (@(posedge clk) disable iff (rst)
        (enter_i && enter_ta_i == '0) |=> imm_q);

    assert_idle_stays_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!imm_q && !armed_q && !enter_i) |=> !imm_q);

    assert_pending_masks_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && cnt_q == TA_W'(1) && pending_i && !enter_i) |=> !imm_q);

endmodule

// File: rtl/evseq_ports.sv
module evseq_ports #(
    parameter int N_PORTS = 2,
    parameter int PW      = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] strobe_i,
    input  logic [N_PORTS-1:0] listen_i,
    input  logic               clear_i,
    output logic [N_PORTS-1:0] flags_o,
    output logic               sel_valid_o,
    output logic [PW-1:0]      sel_port_o
);

    logic [N_PORTS-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | (strobe_i & listen_i);
        end
    end

    always_comb begin
        sel_valid_o = 1'b0;
        sel_port_o  = '0;
        for (int p = N_PORTS - 1; p >= 0; p--) begin
            if (flags_q[p]) begin
                sel_valid_o = 1'b1;
                sel_port_o  = PW'(p);
            end
        end
    end

    assign flags_o = flags_q;

    assert_only_listened_set_R7: assert property (@(posedge clk) disable iff (rst)
        ((flags_q & ~$past(flags_q) & ~$past(strobe_i & listen_i)) == '0));

endmodule

// File: rtl/evseq_table.sv
module evseq_table #(
    parameter int N_STATES = 4,
    parameter int N_PORTS  = 2,
    parameter int TA_W     = 4,
    parameter int OUT_W    = 8,
    parameter int SW       = 2,
    parameter int PW       = 1,
    parameter logic [N_STATES*TA_W-1:0]       TA_TABLE  = '0,
    parameter logic [N_STATES*SW-1:0]         INT_NEXT  = '0,
    parameter logic [N_STATES*OUT_W-1:0]      OUT_TABLE = '0,
    parameter logic [N_STATES*N_PORTS-1:0]    LISTEN    = '0,
    parameter logic [N_STATES*N_PORTS*SW-1:0] EXT_NEXT  = '0
) (
    input  logic [SW-1:0]      cur_idx_i,
    input  logic [PW-1:0]      port_i,
    input  logic [SW-1:0]      query_idx_i,
    output logic [SW-1:0]      int_next_o,
    output logic [SW-1:0]      ext_next_o,
    output logic [OUT_W-1:0]   out_val_o,
    output logic [N_PORTS-1:0] listen_o,
    output logic [TA_W-1:0]    query_ta_o
);

    logic [TA_W-1:0]    ta_row     [N_STATES];
    logic [SW-1:0]      int_row    [N_STATES];
    logic [OUT_W-1:0]   out_row    [N_STATES];
    logic [N_PORTS-1:0] listen_row [N_STATES];
    logic [SW-1:0]      ext_row    [N_STATES][N_PORTS];

    for (genvar s = 0; s < N_STATES; s++) begin : g_state
        assign ta_row[s]     = TA_TABLE[s*TA_W +: TA_W];
        assign int_row[s]    = INT_NEXT[s*SW +: SW];
        assign out_row[s]    = OUT_TABLE[s*OUT_W +: OUT_W];
        assign listen_row[s] = LISTEN[s*N_PORTS +: N_PORTS];
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            assign ext_row[s][p] = EXT_NEXT[(s*N_PORTS + p)*SW +: SW];
        end
    end

    always_comb begin
        int_next_o = '0;
        out_val_o  = '0;
        listen_o   = '0;
        ext_next_o = '0;
        query_ta_o = '0;
        for (int s = 0; s < N_STATES; s++) begin
            if (SW'(s) == cur_idx_i) begin
                int_next_o = int_row[s];
                out_val_o  = out_row[s];
                listen_o   = listen_row[s];
                for (int p = 0; p < N_PORTS; p++) begin
                    if (PW'(p) == port_i) ext_next_o = ext_row[s][p];
                end
            end
            if (SW'(s) == query_idx_i) query_ta_o = ta_row[s];
        end
    end

endmodule

// File: rtl/evseq_atomic.sv
module evseq_atomic
    import evseq_pkg::*;
#(
    parameter int N_STATES = 4,
    parameter int N_PORTS  = 2,
    parameter int TA_W     = 4,
    parameter int OUT_W    = 8,
    parameter logic [N_STATES*TA_W-1:0] TA_TABLE =
        {4'd5, 4'hF, 4'd0, 4'd3},
    parameter logic [N_STATES*((N_STATES > 1) ? $clog2(N_STATES) : 1)-1:0] INT_NEXT =
        {2'd0, 2'd0, 2'd2, 2'd1},
    parameter logic [N_STATES*OUT_W-1:0] OUT_TABLE =
        {8'hD3, 8'hC2, 8'hB1, 8'hA0},
    parameter logic [N_STATES*N_PORTS-1:0] LISTEN =
        {2'b00, 2'b11, 2'b10, 2'b01},
    parameter logic [N_STATES*N_PORTS*((N_STATES > 1) ? $clog2(N_STATES) : 1)-1:0] EXT_NEXT =
        {2'd0, 2'd0, 2'd3, 2'd0, 2'd3, 2'd0, 2'd0, 2'd2}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                speak_req,
    output logic                speak_ack,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data,
    input  logic                move_req,
    output logic                move_ack,
    input  logic [N_PORTS-1:0]  in_strobe,
    output logic [N_STATES-1:0] cur_state,
    output logic                imminent
);

    localparam int SW = (N_STATES > 1) ? $clog2(N_STATES) : 1;
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [N_STATES-1:0] state_q;
    logic [SW-1:0]       cur_idx;
    logic [SW-1:0]       int_next;
    logic [SW-1:0]       ext_next;
    logic [OUT_W-1:0]    out_val;
    logic [N_PORTS-1:0]  listen;
    logic [TA_W-1:0]     next_ta;
    logic [N_PORTS-1:0]  flags;
    logic                sel_valid;
    logic [PW-1:0]       sel_port;
    logic                imm;
    move_dec_t           dec;
    logic [SW-1:0]       next_idx;
    logic                enter;

    logic                speak_ack_q;
    logic                out_valid_q;
    logic [OUT_W-1:0]    out_data_q;
    logic                move_ack_q;

    always_comb begin
        cur_idx = '0;
        for (int s = 0; s < N_STATES; s++) begin
            if (state_q[s]) cur_idx = SW'(s);
        end
    end

    evseq_table #(
        .N_STATES (N_STATES), .N_PORTS (N_PORTS), .TA_W (TA_W), .OUT_W (OUT_W),
        .SW (SW), .PW (PW),
        .TA_TABLE (TA_TABLE), .INT_NEXT (INT_NEXT), .OUT_TABLE (OUT_TABLE),
        .LISTEN (LISTEN), .EXT_NEXT (EXT_NEXT)
    ) u_table (
        .cur_idx_i   (cur_idx),
        .port_i      (sel_port),
        .query_idx_i (next_idx),
        .int_next_o  (int_next),
        .ext_next_o  (ext_next),
        .out_val_o   (out_val),
        .listen_o    (listen),
        .query_ta_o  (next_ta)
    );

    evseq_ports #(.N_PORTS (N_PORTS), .PW (PW)) u_ports (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (in_strobe),
        .listen_i    (listen),
        .clear_i     (enter),
        .flags_o     (flags),
        .sel_valid_o (sel_valid),
        .sel_port_o  (sel_port)
    );

    evseq_timer #(.TA_W (TA_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .enter_i    (enter),
        .enter_ta_i (next_ta),
        .reset_ta_i (TA_TABLE[TA_W-1:0]),
        .pending_i  (sel_valid),
        .imminent_o (imm)
    );

    // Scheduled transition outranks any pending input.
    always_comb begin
        dec.kind     = MV_NONE;
        dec.next_idx = '0;
        if (move_req) begin
            if (imm) begin
                dec.kind     = MV_INTERNAL;
                dec.next_idx = IDX_MAX_W'(int_next);
            end else if (sel_valid) begin
                dec.kind     = MV_EXTERNAL;
                dec.next_idx = IDX_MAX_W'(ext_next);
            end
        end
        next_idx = SW'(dec.next_idx);
        enter    = (dec.kind != MV_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= N_STATES'(1);
        end else if (enter) begin
            state_q <= N_STATES'(1) << next_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            speak_ack_q <= 1'b0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            move_ack_q  <= 1'b0;
        end else begin
            speak_ack_q <= speak_req;
            out_valid_q <= speak_req && imm;
            out_data_q  <= (speak_req && imm) ? out_val : '0;
            move_ack_q  <= move_req;
        end
    end

    assign speak_ack = speak_ack_q;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign move_ack  = move_ack_q;
    assign cur_state = state_q;
    assign imminent  = imm;

    assert_state_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_q));

    assert_speak_handshake_R4: assert property (@(posedge clk) disable iff (rst)
        speak_req |=> speak_ack);

    assert_valid_needs_due_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(imm));

    assert_move_handshake_R5: assert property (@(posedge clk) disable iff (rst)
        move_req |=> move_ack);

    assert_scheduled_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (move_req && imm) |=> (flags == '0) && state_q[$past(int_next)]);

    assert_idle_move_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (move_req && !imm && flags == '0) |=> $stable(state_q));

endmodule

// File: tb/tb_evseq_atomic.sv
module tb_evseq_atomic;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speak_req = 1'b0;
    logic       speak_ack;
    logic       out_valid;
    logic [7:0] out_data;
    logic       move_req = 1'b0;
    logic       move_ack;
    logic [1:0] in_strobe = 2'b00;
    logic [3:0] cur_state;
    logic       imminent;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    evseq_atomic dut (
        .clk       (clk),
        .rst       (rst),
        .speak_req (speak_req),
        .speak_ack (speak_ack),
        .out_valid (out_valid),
        .out_data  (out_data),
        .move_req  (move_req),
        .move_ack  (move_ack),
        .in_strobe (in_strobe),
        .cur_state (cur_state),
        .imminent  (imminent)
    );

    // Expected table, written from the requirements.
    function automatic logic [7:0] out_of(input int s);
        return 8'hA0 + 8'(s * 8'h11);
    endfunction

    function automatic logic [3:0] oh(input int s);
        return 4'(1 << s);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_speak(input string tag, input int s, input logic due);
        speak_req = 1'b1;
        step();
        speak_req = 1'b0;
        check({tag, " speak_ack"}, 32'(speak_ack), 32'd1);
        check({tag, " out_valid"}, 32'(out_valid), 32'(due));
        check({tag, " out_data"}, 32'(out_data), due ? 32'(out_of(s)) : 32'd0);
    endtask

    task automatic do_move(input string tag, input int s_exp);
        move_req = 1'b1;
        step();
        move_req = 1'b0;
        check({tag, " move_ack"}, 32'(move_ack), 32'd1);
        check({tag, " state"}, 32'(cur_state), 32'(oh(s_exp)));
    endtask

    task automatic strobe(input logic [1:0] v);
        in_strobe = v;
        step();
        in_strobe = 2'b00;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10 state", 32'(cur_state), 32'(oh(0)));
        check("R10 imminent", 32'(imminent), 32'd0);
        check("R10 speak_ack", 32'(speak_ack), 32'd0);
        check("R10 move_ack", 32'(move_ack), 32'd0);
        check("R10 out_valid", 32'(out_valid), 32'd0);

        // R4: speaking while not due (edge 1 after reset)
        do_speak("R4 passive", 0, 1'b0);
        step();
        check("R2 ta3 edge2", 32'(imminent), 32'd0);
        step();
        check("R2 ta3 edge3", 32'(imminent), 32'd1);

        do_speak("R4 due s0", 0, 1'b1);
        // R5 + R2: internal to state 1 (lifespan 0)
        do_move("R5 s0->s1", 1);
        check("R2 ta0 at once", 32'(imminent), 32'd1);
        do_speak("R4 due s1", 1, 1'b1);
        do_move("R5 s1->s2", 2);
        check("R5 imminent cleared", 32'(imminent), 32'd0);

        // R1: lifespan "never"
        for (int i = 0; i < 20; i++) begin
            step();
            check("R1 never due", 32'(imminent), 32'd0);
        end
        do_speak("R1 R4 silent", 2, 1'b0);
        do_move("R9 R1 idle move", 2);

        // R6: external on port 1 to state 3
        strobe(2'b10);
        do_move("R6 s2 port1", 3);

        // R7: port 0 is deaf in state 3; lifespan 5 still expires
        strobe(2'b01);
        for (int i = 2; i <= 4; i++) begin
            step();
            check("R7 R2 ta5 early", 32'(imminent), 32'd0);
        end
        step();
        check("R7 R2 ta5 expiry", 32'(imminent), 32'd1);
        do_move("R5 s3->s0", 0);

        // R3: pending input masks expiry of state 0
        strobe(2'b01);
        for (int i = 0; i < 6; i++) begin
            step();
            check("R3 masked", 32'(imminent), 32'd0);
        end
        do_move("R6 s0 port0", 2);

        // R6: both ports strike together, port 0 wins
        strobe(2'b11);
        do_move("R6 port priority", 0);

        // R8: due and input pending in state 0
        step();
        step();
        step();
        check("R8 due", 32'(imminent), 32'd1);
        strobe(2'b01);
        do_move("R8 internal wins", 1);
        do_move("R8 s1->s2", 2);
        // a stale port-0 flag would now lead back to state 0
        do_move("R8 R9 flag dropped", 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule